// File: doc/BRIEF.md
# RTC Alarm and Update Interrupt Generator

This block watches the running time of a real-time clock and turns it into two kinds of interrupt events. A strobe arrives once per second together with the current time in BCD: seconds, minutes, hours and day of month. The weekday arrives as a one-hot vector. From these inputs the block decides whether a periodic update event is due and whether the programmed alarm has been reached.

An update event can be chosen to occur every second or once per minute. The alarm compares minute, hour and a day field. The day field holds either a BCD day of month or a one-hot weekday mask, chosen by a mode input. The alarm is examined only at second zero.

Each event sets a sticky flag, and any evaluation that produces an event emits one single-cycle interrupt pulse. The surrounding register file owns the time counters and software access. It supplies the enable and mode bits and clears the flags through single-cycle clear strobes.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `updFlag`, `almFlag` and `irqPulse` are 0.
- R2: A tick is evaluated only when `curSec` differs from the seconds value stored at the last evaluation or arming. A repeated tick with the same seconds value produces no flag change and no pulse.
- R3: With `updIntEn`=1 and `updPerMinute`=0, every evaluated tick sets `updFlag` and pulses `irqPulse`. Both outputs change at the clock edge that samples the tick.
- R4: With `updIntEn`=1 and `updPerMinute`=1, an evaluated tick sets `updFlag` only when `curMin` differs from the minute of the previous update event. That event then becomes the new reference minute.
- R5: In the cycle where `updIntEn` or `almIntEn` goes from 0 to 1, the current seconds value is stored as the reference and no evaluation takes place. A 0 to 1 change of `updIntEn` also stores the current minute as the reference.
- R6: With `almIntEn`=1 and `alarmOnDate`=0, the alarm requires three matches on an evaluated tick with `curSec`=8'h00. `alarmMin` must equal `curMin`, `alarmHour` must equal `curHour`, and `alarmDay` must equal {1'b0, `curWday`}, where bit n of `curWday` marks weekday n. A match sets `almFlag` and pulses `irqPulse`.
- R7: With `alarmOnDate`=1, the alarm day comparison uses the BCD `curMday` in place of the weekday mask.
- R8: No alarm event occurs when the seconds value is nonzero, or when the minute, hour or day comparison fails.
- R9: `irqPulse` is high for exactly one clock per evaluation that produces an event. This holds even when update and alarm events coincide.
- R10: While both `updIntEn` and `almIntEn` are 0, ticks set no flag and produce no pulse.
- R11: `updFlag` and `almFlag` remain set until a one-cycle pulse on `updFlagClr` or `almFlagClr` clears the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | Once-per-second evaluation strobe |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curMday | input | 8 | Current day of month, BCD |
| curWday | input | 7 | Current weekday, one-hot |
| alarmMin | input | 8 | Alarm minute, BCD |
| alarmHour | input | 8 | Alarm hour, BCD |
| alarmDay | input | 8 | Alarm day: BCD date or weekday mask |
| updIntEn | input | 1 | Update interrupt enable |
| almIntEn | input | 1 | Alarm interrupt enable |
| updPerMinute | input | 1 | 1: update per minute, 0: per second |
| alarmOnDate | input | 1 | 1: alarm day is a date, 0: a weekday |
| updFlagClr | input | 1 | Clears the update flag |
| almFlagClr | input | 1 | Clears the alarm flag |
| updFlag | output | 1 | Sticky update event flag |
| almFlag | output | 1 | Sticky alarm event flag |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach is an alarm match that lands in the same second as a per-minute update event. That case needs second zero, a new minute, and matching hour and day fields all at once. Random stimulus therefore draws minutes, hours and day values from small pools that overlap the alarm registers, and it picks second zero often. Directed steps add the arming cycle, the repeated-second tick, and both day compare modes.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  // Strobes from the decision logic to the datapath, valid for one cycle.
  typedef struct packed {
    logic armUpd;   // update enable rose: capture second and minute
    logic armAlm;   // alarm enable rose: capture second
    logic evalStb;  // this tick is a new second and will be evaluated
    logic setUpd;   // raise the update flag
    logic setAlm;   // raise the alarm flag
    logic takeMin;  // adopt current minute as per-minute reference
  } ctrl_strobe_t;

endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         secTick,
  input  logic         updIntEn,
  input  logic         almIntEn,
  input  logic         updPerMinute,
  input  logic         secAdvanced,
  input  logic         minChanged,
  input  logic         secZero,
  input  logic         alarmHit,
  output ctrl_strobe_t stb
);

  logic updEnQ;
  logic almEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updEnQ <= 1'b0;
      almEnQ <= 1'b0;
    end else begin
      updEnQ <= updIntEn;
      almEnQ <= almIntEn;
    end
  end

  always_comb begin
    stb         = '0;
    stb.armUpd  = updIntEn & ~updEnQ;
    stb.armAlm  = almIntEn & ~almEnQ;
    // An arming cycle only records references; evaluation waits.
    stb.evalStb = secTick & (updIntEn | almIntEn) & ~stb.armUpd
                & ~stb.armAlm & secAdvanced;
    stb.setUpd  = stb.evalStb & updIntEn & (~updPerMinute | minChanged);
    stb.setAlm  = stb.evalStb & almIntEn & secZero & alarmHit;
    stb.takeMin = stb.setUpd & updPerMinute;
  end

  // R5: arming and evaluating never share a cycle
  assert_arm_excludes_eval_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updIntEn) |-> !stb.setUpd);

endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
#(
  parameter int TIME_W = 8,
  parameter int WDAY_N = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] curSec,
  input  logic [TIME_W-1:0] curMin,
  input  logic [TIME_W-1:0] curHour,
  input  logic [TIME_W-1:0] curMday,
  input  logic [WDAY_N-1:0] curWday,
  input  logic [TIME_W-1:0] alarmMin,
  input  logic [TIME_W-1:0] alarmHour,
  input  logic [TIME_W-1:0] alarmDay,
  input  logic              alarmOnDate,
  input  logic              updFlagClr,
  input  logic              almFlagClr,
  input  ctrl_strobe_t      stb,
  output logic              secAdvanced,
  output logic              minChanged,
  output logic              secZero,
  output logic              alarmHit,
  output logic              updFlag,
  output logic              almFlag,
  output logic              irqPulse
);

  localparam int PAD_W = TIME_W - WDAY_N;

  logic [TIME_W-1:0] lastSec;
  logic [TIME_W-1:0] lastMin;
  logic [TIME_W-1:0] wdayWide;
  logic [TIME_W-1:0] dayRef;

  generate
    if (PAD_W > 0) begin : g_pad
      assign wdayWide = {{PAD_W{1'b0}}, curWday};
    end else begin : g_nopad
      assign wdayWide = curWday[TIME_W-1:0];
    end
  endgenerate

  assign dayRef      = alarmOnDate ? curMday : wdayWide;
  assign secAdvanced = (curSec != lastSec);
  assign minChanged  = (curMin != lastMin);
  assign secZero     = (curSec == '0);
  assign alarmHit    = (alarmMin == curMin) && (alarmHour == curHour)
                    && (alarmDay == dayRef);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSec <= '0;
      lastMin <= '0;
    end else begin
      if (stb.armUpd || stb.armAlm || stb.evalStb) lastSec <= curSec;
      if (stb.armUpd || stb.takeMin) lastMin <= curMin;
    end
  end

  // Set has priority over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updFlag  <= 1'b0;
      almFlag  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (stb.setUpd)      updFlag <= 1'b1;
      else if (updFlagClr) updFlag <= 1'b0;
      if (stb.setAlm)      almFlag <= 1'b1;
      else if (almFlagClr) almFlag <= 1'b0;
      irqPulse <= stb.setUpd | stb.setAlm;
    end
  end

  // R8: alarm flag rises only after a second-zero sample
  assert_alarm_at_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(almFlag) |-> ($past(curSec) == '0));

  // R9: a pulse always comes with at least one raised flag
  assert_pulse_has_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (updFlag || almFlag));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int TIME_W = 8,
  parameter int WDAY_N = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [TIME_W-1:0] curSec,
  input  logic [TIME_W-1:0] curMin,
  input  logic [TIME_W-1:0] curHour,
  input  logic [TIME_W-1:0] curMday,
  input  logic [WDAY_N-1:0] curWday,
  input  logic [TIME_W-1:0] alarmMin,
  input  logic [TIME_W-1:0] alarmHour,
  input  logic [TIME_W-1:0] alarmDay,
  input  logic              updIntEn,
  input  logic              almIntEn,
  input  logic              updPerMinute,
  input  logic              alarmOnDate,
  input  logic              updFlagClr,
  input  logic              almFlagClr,
  output logic              updFlag,
  output logic              almFlag,
  output logic              irqPulse
);

  ctrl_strobe_t stb;
  logic secAdvanced;
  logic minChanged;
  logic secZero;
  logic alarmHit;

  rtc_irq_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .secTick      (secTick),
    .updIntEn     (updIntEn),
    .almIntEn     (almIntEn),
    .updPerMinute (updPerMinute),
    .secAdvanced  (secAdvanced),
    .minChanged   (minChanged),
    .secZero      (secZero),
    .alarmHit     (alarmHit),
    .stb          (stb)
  );

  rtc_irq_dp #(.TIME_W(TIME_W), .WDAY_N(WDAY_N)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .curSec      (curSec),
    .curMin      (curMin),
    .curHour     (curHour),
    .curMday     (curMday),
    .curWday     (curWday),
    .alarmMin    (alarmMin),
    .alarmHour   (alarmHour),
    .alarmDay    (alarmDay),
    .alarmOnDate (alarmOnDate),
    .updFlagClr  (updFlagClr),
    .almFlagClr  (almFlagClr),
    .stb         (stb),
    .secAdvanced (secAdvanced),
    .minChanged  (minChanged),
    .secZero     (secZero),
    .alarmHit    (alarmHit),
    .updFlag     (updFlag),
    .almFlag     (almFlag),
    .irqPulse    (irqPulse)
  );

  // R2: a pulse needs a tick in the previous cycle
  assert_pulse_follows_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(secTick));

  // R10: with both enables off nothing is raised next cycle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!updIntEn && !almIntEn) |=> !irqPulse);

  // R3: update flag only rises while updates are enabled
  assert_update_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updFlag) |-> $past(updIntEn));

  // R5: the arming cycle produces no pulse
  assert_arm_no_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(updIntEn) || $rose(almIntEn)) |=> !irqPulse);

endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [7:0] curSec = 8'h00, curMin = 8'h00, curHour = 8'h00, curMday = 8'h01;
  logic [6:0] curWday = 7'h01;
  logic [7:0] alarmMin = 8'h00, alarmHour = 8'h00, alarmDay = 8'h00;
  logic       updIntEn = 1'b0, almIntEn = 1'b0, updPerMinute = 1'b0, alarmOnDate = 1'b0;
  logic       updFlagClr = 1'b0, almFlagClr = 1'b0;
  logic       updFlag, almFlag, irqPulse;

  int errors = 0;
  int checks = 0;

  // bench reference state
  logic [7:0] mLastSec = 8'h00, mLastMin = 8'h00;
  logic       mUf = 1'b0, mAf = 1'b0, mUie = 1'b0, mAie = 1'b0;

  always #5 clk = ~clk;

  rtc_alarm_irq dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curMday(curMday),
    .curWday(curWday), .alarmMin(alarmMin), .alarmHour(alarmHour),
    .alarmDay(alarmDay), .updIntEn(updIntEn), .almIntEn(almIntEn),
    .updPerMinute(updPerMinute), .alarmOnDate(alarmOnDate),
    .updFlagClr(updFlagClr), .almFlagClr(almFlagClr),
    .updFlag(updFlag), .almFlag(almFlag), .irqPulse(irqPulse)
  );

  function automatic logic [7:0] toBcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic alarmMatches(logic [7:0] m, logic [7:0] h,
                                        logic [7:0] md, logic [6:0] wd);
    logic [7:0] ref8;
    ref8 = alarmOnDate ? md : {1'b0, wd};
    return (alarmMin == m) && (alarmHour == h) && (alarmDay == ref8);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setEnables(logic u, logic a, logic usel, logic wada);
    @(negedge clk);
    updIntEn = u; almIntEn = a; updPerMinute = usel; alarmOnDate = wada;
    @(negedge clk);
    if (u && !mUie) begin mLastSec = curSec; mLastMin = curMin; end
    if (a && !mAie) mLastSec = curSec;
    mUie = u; mAie = a;
    check("R5 arming pulse", irqPulse, 1'b0);
  endtask

  task automatic clearFlags(logic cu, logic ca);
    @(negedge clk);
    updFlagClr = cu; almFlagClr = ca;
    @(negedge clk);
    updFlagClr = 1'b0; almFlagClr = 1'b0;
    if (cu) mUf = 1'b0;
    if (ca) mAf = 1'b0;
    check("R11 update flag after clear", updFlag, mUf);
    check("R11 alarm flag after clear", almFlag, mAf);
  endtask

  task automatic doTick(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                        logic [7:0] md, logic [6:0] wd, string tag);
    logic up, al;
    up = 1'b0; al = 1'b0;
    @(negedge clk);
    curSec = s; curMin = m; curHour = h; curMday = md; curWday = wd;
    secTick = 1'b1;
    if ((mUie || mAie) && (s != mLastSec)) begin
      mLastSec = s;
      up = mUie && (!updPerMinute || (m != mLastMin));
      if (up && updPerMinute) mLastMin = m;
      al = mAie && (s == 8'h00) && alarmMatches(m, h, md, wd);
    end
    if (up) mUf = 1'b1;
    if (al) mAf = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    check({tag, " pulse"}, irqPulse, up || al);
    check({tag, " update flag"}, updFlag, mUf);
    check({tag, " alarm flag"}, almFlag, mAf);
    @(negedge clk);
    check("R9 pulse width", irqPulse, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset update flag", updFlag, 1'b0);
    check("R1 reset alarm flag", almFlag, 1'b0);
    check("R1 reset pulse", irqPulse, 1'b0);

    // R10: idle block ignores ticks
    doTick(8'h05, 8'h10, 8'h09, 8'h03, 7'h02, "R10 idle");
    doTick(8'h00, 8'h11, 8'h09, 8'h03, 7'h02, "R10 idle");

    // R5 / R2 / R3: per-second updates
    doTick(8'h05, 8'h10, 8'h09, 8'h03, 7'h02, "R10 idle");
    setEnables(1'b1, 1'b0, 1'b0, 1'b0);
    doTick(8'h05, 8'h10, 8'h09, 8'h03, 7'h02, "R5 reference second");
    doTick(8'h06, 8'h10, 8'h09, 8'h03, 7'h02, "R3 new second");
    doTick(8'h06, 8'h10, 8'h09, 8'h03, 7'h02, "R2 repeated second");
    doTick(8'h07, 8'h10, 8'h09, 8'h03, 7'h02, "R3 next second");
    clearFlags(1'b1, 1'b0);

    // R4: per-minute updates
    setEnables(1'b1, 1'b0, 1'b1, 1'b0);
    doTick(8'h08, 8'h10, 8'h09, 8'h03, 7'h02, "R4 same minute");
    doTick(8'h09, 8'h11, 8'h09, 8'h03, 7'h02, "R4 new minute");
    doTick(8'h10, 8'h11, 8'h09, 8'h03, 7'h02, "R4 after minute");
    clearFlags(1'b1, 1'b0);

    // R6 / R9: weekday alarm together with a minute update
    alarmMin = 8'h30; alarmHour = 8'h12; alarmDay = 8'h08;
    setEnables(1'b1, 1'b1, 1'b1, 1'b0);
    doTick(8'h00, 8'h30, 8'h12, 8'h15, 7'h08, "R6 weekday alarm");
    check("R9 both flags", updFlag && almFlag, 1'b1);
    clearFlags(1'b1, 1'b1);

    // R7: date alarm
    setEnables(1'b0, 1'b1, 1'b0, 1'b1);
    alarmDay = 8'h15;
    doTick(8'h59, 8'h30, 8'h12, 8'h15, 7'h08, "R8 nonzero second");
    doTick(8'h00, 8'h30, 8'h12, 8'h15, 7'h01, "R7 date alarm");
    clearFlags(1'b0, 1'b1);

    // R8: mismatches
    doTick(8'h01, 8'h30, 8'h12, 8'h15, 7'h01, "R8 second one");
    doTick(8'h00, 8'h30, 8'h13, 8'h15, 7'h01, "R8 hour mismatch");
    doTick(8'h01, 8'h30, 8'h12, 8'h15, 7'h01, "R8 second one");
    doTick(8'h00, 8'h30, 8'h12, 8'h16, 7'h01, "R8 date mismatch");

    // Random phase
    for (int i = 0; i < 500; i++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 2) begin
        setEnables(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end else if (r < 4) begin
        clearFlags(1'($urandom), 1'($urandom));
      end else if (r < 5) begin
        @(negedge clk);
        alarmMin  = 8'h30 + 8'($urandom % 3);
        alarmHour = 8'h12 + 8'($urandom % 2);
        alarmDay  = ($urandom % 2) ? (8'h14 + 8'($urandom % 2))
                                   : (8'h01 << ($urandom % 7));
      end else begin
        logic [7:0] s;
        int sr;
        sr = int'($urandom % 4);
        s = (sr == 0) ? 8'h00 : (sr == 1) ? mLastSec : toBcd(int'($urandom % 60));
        doTick(s, 8'h30 + 8'($urandom % 3), 8'h12 + 8'($urandom % 2),
               8'h14 + 8'($urandom % 2), 7'h01 << ($urandom % 7), "R3 R6 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule